// File: doc/BRIEF.md
# Edge-Selectable Peripheral Interrupt Controller

This block collects the interrupt sources of an 8-bit peripheral adapter into one flag register and drives a single active-high interrupt request. Four external handshake lines (two per data port, named A1, A2, B1 and B2 here) arrive asynchronously. Each is synchronized, compared with a registered copy of itself, and latches its flag on the edge that a peripheral-control register selects. A shift-register completion event and two timer events arrive as single-cycle pulses from neighbouring logic and set their flags directly.

Software reaches three byte-wide registers through a small address/data interface. The flag register reads back the raw flags with an "any enabled flag active" summary in bit 7, and a write clears the flags whose bits are written as 1. The enable register is changed through a set/clear selector in bit 7. The peripheral-control register holds the edge polarity of each line and an independent-mode bit for A2 and B2. The port-access logic sends side-effect pulses: any access to port A (with or without handshake) or to port B clears that port's handshake flags, and a shift-register read clears the shift flag.

Top module: `periph_irq_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when some flag bit and the matching enable bit are both 1.
- R2: Control bit 0 sets A1 polarity and control bit 4 sets B1 polarity: 1 latches the flag (bit 1 for A1, bit 4 for B1) on a rising edge of the synchronized line, 0 on a falling edge; the other edge leaves the flag unchanged.
- R3: A2 takes its polarity from control bit 2 and B2 from control bit 6 (1 rising, 0 falling), setting flag bit 0 and flag bit 3; control bit 1 (A2) and bit 5 (B2) select independent mode, in which port accesses leave that flag unchanged. Control bits 3 and 7 are stored but not decoded.
- R4: A pulse on `sr_evt_i` sets flag bit 2 without any edge gating; a pulse on `sr_rd_i` clears it.
- R5: A pulse on `tmr1_evt_i` sets flag bit 6 and a pulse on `tmr2_evt_i` sets flag bit 5.
- R6: Register addresses are 0 flag, 1 enable, 2 control, 3 unused (reads 0x00, writes ignored). Reading address 0 returns bit 7 equal to `irq_o` and bits 6..0 equal to the flags.
- R7: A write to address 0 clears each flag whose data bit is 1 and leaves the others unchanged.
- R8: A write to address 1 with data bit 7 = 1 sets the enable bits written as 1 in bits 6..0; with bit 7 = 0 it clears them; reading address 1 returns bit 7 as 1.
- R9: A pulse on `porta_acc_i` clears flag bit 1 and, unless A2 is independent, flag bit 0; a pulse on `portb_acc_i` clears flag bit 4 and, unless B2 is independent, flag bit 3.
- R10: After reset the flag, enable and control registers are all zero and `irq_o` is 0.
- R11: When a flag is set and cleared in the same cycle, the set wins and the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_a1_i | input | 1 | Port A handshake line 1, asynchronous |
| hs_a2_i | input | 1 | Port A handshake line 2, asynchronous |
| hs_b1_i | input | 1 | Port B handshake line 1, asynchronous |
| hs_b2_i | input | 1 | Port B handshake line 2, asynchronous |
| sr_evt_i | input | 1 | Shift-register event pulse |
| sr_rd_i | input | 1 | Shift-register read side-effect pulse |
| tmr1_evt_i | input | 1 | Timer 1 event pulse |
| tmr2_evt_i | input | 1 | Timer 2 event pulse |
| porta_acc_i | input | 1 | Port A read or write (either address) side-effect pulse |
| portb_acc_i | input | 1 | Port B read or write side-effect pulse |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The two functions that can fall in the same cycle are a flag being set by an event and the same flag being cleared by a software write or a side-effect pulse. The bench provokes this by raising a timer pulse in the very cycle that a flag-register write clears bit 6, and by pairing a shift event with a shift-register read pulse; it then reads the flag register and expects both bits still set. Independent mode is judged the same way: a port access lands while A2 or B2 holds its flag, and the bench expects only the line-1 flag to drop.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DW    = 8;
  localparam int NFLAG = DW - 1;
  localparam int AW    = 2;
  localparam int NLINE = 4;

  // flag bit positions
  localparam int F_A2 = 0;
  localparam int F_A1 = 1;
  localparam int F_SR = 2;
  localparam int F_B2 = 3;
  localparam int F_B1 = 4;
  localparam int F_T2 = 5;
  localparam int F_T1 = 6;

  // edge-detector lane order
  localparam int L_A2 = 0;
  localparam int L_A1 = 1;
  localparam int L_B2 = 2;
  localparam int L_B1 = 3;

  // control register bit positions
  localparam int C_A1_POL = 0;
  localparam int C_A2_IND = 1;
  localparam int C_A2_POL = 2;
  localparam int C_B1_POL = 4;
  localparam int C_B2_IND = 5;
  localparam int C_B2_POL = 6;

  typedef enum logic [AW-1:0] {
    ADR_FLAG = 2'd0,
    ADR_EN   = 2'd1,
    ADR_CTL  = 2'd2,
    ADR_NONE = 2'd3
  } adr_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pirq_edge.sv
module pirq_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise_sel,
  output logic [N-1:0] hit
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic up, dn;
    assign up     = lvl[g] & ~prev_q[g];
    assign dn     = ~lvl[g] & prev_q[g];
    assign hit[g] = rise_sel[g] ? up : dn;
  end
endmodule

// File: rtl/pirq_flags.sv
module pirq_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic         flag_en;

  // set takes priority over clear in the same cycle
  always_comb begin
    flag_en = (|set_vec) | (|clr_vec);
    flag_d  = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [NFLAG-1:0] flag_q,
  input  logic             irq,
  output logic [NFLAG-1:0] en_q,
  output logic [NFLAG-1:0] wr_clr,
  output logic [NLINE-1:0] rise_sel,
  output logic             a2_ind,
  output logic             b2_ind,
  output logic [DW-1:0]    reg_rdata_o
);
  adr_e             adr;
  logic [DW-1:0]    ctl_q, ctl_d;
  logic             ctl_we;
  logic [NFLAG-1:0] en_d;
  logic             en_we;
  logic [NFLAG-1:0] wmask;

  assign adr   = adr_e'(reg_addr_i);
  assign wmask = reg_wdata_i[NFLAG-1:0];

  always_comb begin
    ctl_we = reg_wr_i && (adr == ADR_CTL);
    ctl_d  = reg_wdata_i;
    en_we  = reg_wr_i && (adr == ADR_EN);
    en_d   = reg_wdata_i[DW-1] ? (en_q | wmask) : (en_q & ~wmask);
    wr_clr = (reg_wr_i && (adr == ADR_FLAG)) ? wmask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_comb begin
    rise_sel        = '0;
    rise_sel[L_A2]  = ctl_q[C_A2_POL];
    rise_sel[L_A1]  = ctl_q[C_A1_POL];
    rise_sel[L_B2]  = ctl_q[C_B2_POL];
    rise_sel[L_B1]  = ctl_q[C_B1_POL];
    a2_ind          = ctl_q[C_A2_IND];
    b2_ind          = ctl_q[C_B2_IND];
  end

  always_comb begin
    unique case (adr)
      ADR_FLAG: reg_rdata_o = {irq, flag_q};
      ADR_EN:   reg_rdata_o = {1'b1, en_q};
      ADR_CTL:  reg_rdata_o = ctl_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_a1_i,
  input  logic          hs_a2_i,
  input  logic          hs_b1_i,
  input  logic          hs_b2_i,
  input  logic          sr_evt_i,
  input  logic          sr_rd_i,
  input  logic          tmr1_evt_i,
  input  logic          tmr2_evt_i,
  input  logic          porta_acc_i,
  input  logic          portb_acc_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [NLINE-1:0] raw_lines, sync_lines, rise_sel, hit;
  logic [NFLAG-1:0] set_vec, clr_vec, side_clr, wr_clr;
  logic [NFLAG-1:0] flag_q, en_q;
  logic             a2_ind, b2_ind;

  always_comb begin
    raw_lines        = '0;
    raw_lines[L_A2]  = hs_a2_i;
    raw_lines[L_A1]  = hs_a1_i;
    raw_lines[L_B2]  = hs_b2_i;
    raw_lines[L_B1]  = hs_b1_i;
  end

  pirq_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  pirq_edge #(.N(NLINE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lines), .rise_sel(rise_sel), .hit(hit)
  );

  always_comb begin
    set_vec       = '0;
    set_vec[F_A2] = hit[L_A2];
    set_vec[F_A1] = hit[L_A1];
    set_vec[F_B2] = hit[L_B2];
    set_vec[F_B1] = hit[L_B1];
    set_vec[F_SR] = sr_evt_i;
    set_vec[F_T2] = tmr2_evt_i;
    set_vec[F_T1] = tmr1_evt_i;

    side_clr       = '0;
    side_clr[F_A1] = porta_acc_i;
    side_clr[F_A2] = porta_acc_i & ~a2_ind;
    side_clr[F_B1] = portb_acc_i;
    side_clr[F_B2] = portb_acc_i & ~b2_ind;
    side_clr[F_SR] = sr_rd_i;

    clr_vec = side_clr | wr_clr;
  end

  pirq_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag_q(flag_q)
  );

  assign irq_o = |(flag_q & en_q);

  pirq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .flag_q(flag_q), .irq(irq_o),
    .en_q(en_q), .wr_clr(wr_clr), .rise_sel(rise_sel),
    .a2_ind(a2_ind), .b2_ind(b2_ind),
    .reg_rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
  import pirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [AW-1:0]    reg_addr_i,
  input logic             reg_wr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             porta_acc_i,
  input logic             a2_ind,
  input logic [NFLAG-1:0] flag_q,
  input logic [NFLAG-1:0] en_q,
  input logic [NFLAG-1:0] set_vec
);
  logic flag_wr, en_wr;
  assign flag_wr = reg_wr_i && (reg_addr_i == ADR_FLAG);
  assign en_wr   = reg_wr_i && (reg_addr_i == ADR_EN);

  assert_irq_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADR_FLAG) |-> (reg_rdata_o[DW-1] == irq_o));

  assert_en_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADR_EN) |-> reg_rdata_o[DW-1]);

  assert_en_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && reg_wdata_i[DW-1]) |=>
      ((en_q & $past(reg_wdata_i[NFLAG-1:0])) == $past(reg_wdata_i[NFLAG-1:0])));

  assert_flag_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(reg_wdata_i[NFLAG-1:0] & ~set_vec)) == '0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  assert_porta_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (porta_acc_i && !set_vec[F_A1]) |=> !flag_q[F_A1]);

  assert_a2_indep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (porta_acc_i && a2_ind && !flag_wr) |=>
      (flag_q[F_A2] == ($past(flag_q[F_A2]) | $past(set_vec[F_A2]))));
endmodule

bind periph_irq_ctrl pirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o),
  .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .porta_acc_i(porta_acc_i), .a2_ind(a2_ind),
  .flag_q(flag_q), .en_q(en_q), .set_vec(set_vec)
);

// File: tb/periph_irq_ctrl_bench.sv
module periph_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_a1 = 0, hs_a2 = 0, hs_b1 = 0, hs_b2 = 0;
  logic       sr_evt = 0, sr_rd = 0, t1 = 0, t2 = 0, pa = 0, pb = 0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         nchk = 0;
  int         nerr = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  periph_irq_ctrl u_periph_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hs_a1_i(hs_a1), .hs_a2_i(hs_a2), .hs_b1_i(hs_b1), .hs_b2_i(hs_b2),
    .sr_evt_i(sr_evt), .sr_rd_i(sr_rd), .tmr1_evt_i(t1), .tmr2_evt_i(t2),
    .porta_acc_i(pa), .portb_acc_i(pb),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {write, addr, data, expected read}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd2, 8'h00, 8'h00},   // R10 control
    {1'b0, 2'd1, 8'h00, 8'h80},   // R10 R8 enable
    {1'b0, 2'd0, 8'h00, 8'h00},   // R10 flags
    {1'b0, 2'd3, 8'h00, 8'h00},   // R6 unused
    {1'b1, 2'd1, 8'hC3, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hC3},   // R8 set
    {1'b1, 2'd1, 8'h02, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hC1},   // R8 clear
    {1'b1, 2'd1, 8'h7F, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h80},   // R8 clear all
    {1'b1, 2'd2, 8'hA5, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'hA5},   // R6 control
    {1'b1, 2'd3, 8'h5A, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h00}    // R6 unused write ignored
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_pa(); @(negedge clk); pa = 1; @(negedge clk); pa = 0; endtask
  task automatic pulse_pb(); @(negedge clk); pb = 1; @(negedge clk); pb = 0; endtask
  task automatic pulse_sr(); @(negedge clk); sr_evt = 1; @(negedge clk); sr_evt = 0; endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 irq after reset", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) reg_wr(VEC[i][17:16], VEC[i][15:8]);
      else reg_rd(VEC[i][17:16], VEC[i][7:0], $sformatf("R6/R8/R10 vector %0d", i));
    end

    reg_wr(2'd2, 8'h00);
    reg_wr(2'd1, 8'hFF);

    // R2: A1 rising
    reg_wr(2'd2, 8'h01);
    hs_a1 = 1; settle();
    reg_rd(2'd0, 8'h82, "R2 A1 rising sets");
    chk("R1 irq with enabled flag", {7'd0, irq}, 8'h01);
    reg_wr(2'd0, 8'h02);
    reg_rd(2'd0, 8'h00, "R7 write clears A1");
    hs_a1 = 0; settle();
    reg_rd(2'd0, 8'h00, "R2 A1 falling ignored when rising");
    // R2: A1 falling
    reg_wr(2'd2, 8'h00);
    hs_a1 = 1; settle();
    reg_rd(2'd0, 8'h00, "R2 A1 rising ignored when falling");
    hs_a1 = 0; settle();
    reg_rd(2'd0, 8'h82, "R2 A1 falling sets");
    reg_wr(2'd0, 8'h7F);
    // R2: B1 rising
    reg_wr(2'd2, 8'h10);
    hs_b1 = 1; settle();
    reg_rd(2'd0, 8'h90, "R2 B1 rising sets");
    reg_wr(2'd0, 8'h7F);
    hs_b1 = 0; settle();
    reg_rd(2'd0, 8'h00, "R2 B1 falling ignored");

    // R3 / R9: A2 normal then independent
    reg_wr(2'd2, 8'h05);
    hs_a1 = 1; hs_a2 = 1; settle();
    reg_rd(2'd0, 8'h83, "R3 A2 rising sets");
    pulse_pa();
    reg_rd(2'd0, 8'h00, "R9 port A clears A1 and A2");
    hs_a1 = 0; hs_a2 = 0; settle();
    reg_wr(2'd2, 8'h07);
    hs_a1 = 1; hs_a2 = 1; settle();
    reg_rd(2'd0, 8'h83, "R3 A2 set in independent mode");
    pulse_pa();
    reg_rd(2'd0, 8'h81, "R3 A2 independent kept, A1 cleared");
    reg_wr(2'd0, 8'h7F);

    // R3 / R9: B2 normal then independent, then falling polarity
    reg_wr(2'd2, 8'h50);
    hs_b1 = 1; hs_b2 = 1; settle();
    reg_rd(2'd0, 8'h98, "R3 B2 rising sets");
    pulse_pb();
    reg_rd(2'd0, 8'h00, "R9 port B clears B1 and B2");
    hs_b1 = 0; hs_b2 = 0; settle();
    reg_wr(2'd2, 8'h70);
    hs_b1 = 1; hs_b2 = 1; settle();
    pulse_pb();
    reg_rd(2'd0, 8'h88, "R3 B2 independent kept, B1 cleared");
    reg_wr(2'd0, 8'h7F);
    reg_wr(2'd2, 8'h00);
    hs_b2 = 0; settle();
    reg_rd(2'd0, 8'h88, "R3 B2 falling sets");
    reg_wr(2'd0, 8'h7F);

    // R4 shift event
    pulse_sr();
    reg_rd(2'd0, 8'h84, "R4 shift event sets");
    pulse_sr();
    reg_rd(2'd0, 8'h84, "R4 second shift event");
    @(negedge clk); sr_rd = 1; @(negedge clk); sr_rd = 0;
    reg_rd(2'd0, 8'h00, "R4 shift read clears");

    // R5 timers
    @(negedge clk); t1 = 1; @(negedge clk); t1 = 0;
    reg_rd(2'd0, 8'hC0, "R5 timer 1 sets bit 6");
    @(negedge clk); t2 = 1; @(negedge clk); t2 = 0;
    reg_rd(2'd0, 8'hE0, "R5 timer 2 sets bit 5");

    // R7 selective clear
    reg_wr(2'd0, 8'h40);
    reg_rd(2'd0, 8'hA0, "R7 clear bit 6 only");

    // R1 enable gating
    reg_wr(2'd1, 8'h7F);
    chk("R1 irq low with no enables", {7'd0, irq}, 8'h00);
    reg_rd(2'd0, 8'h20, "R6 summary bit low");
    reg_wr(2'd1, 8'hC0);
    chk("R1 irq low with other enable", {7'd0, irq}, 8'h00);
    reg_wr(2'd1, 8'hA0);
    chk("R1 irq high with matching enable", {7'd0, irq}, 8'h01);

    // R11 set beats clear
    @(negedge clk);
    addr = 2'd0; wdata = 8'h40; wr = 1; t1 = 1;
    @(negedge clk);
    wr = 0; t1 = 0;
    reg_rd(2'd0, 8'hE0, "R11 timer 1 beats flag write");
    @(negedge clk); sr_evt = 1; sr_rd = 1;
    @(negedge clk); sr_evt = 0; sr_rd = 0;
    reg_rd(2'd0, 8'hE4, "R11 shift event beats shift read");

    // R10 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    reg_rd(2'd0, 8'h00, "R10 flags after reset");
    reg_rd(2'd1, 8'h80, "R10 enables after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule